// File: doc/BRIEF.md
# Multi-Cycle Path Word Crossing

This block carries a multi-bit word from a source clock domain into an unrelated destination clock domain. The word itself is never synchronized. The source captures it into a holding register and keeps it steady. At the same time it flips a single enable level. Only that level crosses, through a chain of destination flops. When the destination sees the synchronized level change, it loads the held word directly. By then the word has been stable for several destination cycles.

The destination returns its own registered copy of the enable level to the source through a two-flop synchronizer. The source accepts no new word until that returned level matches the level it sent. This closed loop limits the crossing to one word in flight. It also guarantees the hold register never changes while the destination may sample it.

On the source side, a word is offered with `src_valid` and is taken in a cycle where `src_ready` is high. On the destination side, `dst_data` changes only together with a single-cycle `dst_valid` pulse.

Top module: `mcp_xfer`

## Requirements
- R1: During and right after reset, `src_ready` is 1, `dst_valid` is 0 and `dst_data` is all zeros.
- R2: A word is accepted on a source clock edge where `src_valid` and `src_ready` are both 1. On the next source cycle, `src_ready` is 0.
- R3: From an acceptance until `src_ready` is 1 again, the word held for the crossing does not change.
- R4: Each accepted word produces exactly one `dst_valid` pulse. Each pulse lasts exactly one destination cycle.
- R5: `dst_data` changes only in cycles where `dst_valid` is 1. Otherwise it keeps its previous value.
- R6: Accepted words arrive at `dst_data` in acceptance order, with every bit intact.
- R7: A new word is never accepted before the previous word has been delivered. When `dst_valid` pulses, exactly one accepted word is outstanding.
- R8: `src_valid` and `src_data` have no effect while `src_ready` is 0. Such words are never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_valid | input | 1 | Source offers a word |
| src_data | input | WIDTH | Offered word |
| src_ready | output | 1 | Source may accept a word |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_data | output | WIDTH | Last delivered word |
| dst_valid | output | 1 | One-cycle pulse marking a new word on dst_data |

## Verification
A stuck or doubled toggle shows at the ports as a missing or extra `dst_valid` pulse. It also leaves `src_ready` low for good, and the bench's timeout reports that within a few thousand cycles. A hold register that changes too early shows as a corrupted word at the next `dst_valid`, which is checked against the queue of accepted words. A broken acknowledge path shows as a second word accepted before the first is delivered. That is caught at the next destination pulse. Words offered while busy carry random values, so any leak of them shows at once as an ordering error.

// File: rtl/mcp_xfer.sv
module mcp_xfer #(
  parameter int WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic             src_valid,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_ready,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [WIDTH-1:0] dst_data,
  output logic             dst_valid
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0]       hold_q;
  logic                   tog_q;
  logic [SYNC_STAGES-1:0] ack_sync_q;
  logic [SYNC_STAGES-1:0] en_sync_q;
  logic                   seen_q;
  logic                   load;
  logic                   take;

  assign src_ready = (ack_sync_q[LAST] == tog_q);
  assign take      = src_valid && src_ready;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      hold_q     <= '0;
      tog_q      <= 1'b0;
      ack_sync_q <= '0;
    end else begin
      ack_sync_q <= {ack_sync_q[SYNC_STAGES-2:0], seen_q};
      if (take) begin
        hold_q <= src_data;
        tog_q  <= ~tog_q;
      end
    end
  end

  assign load = en_sync_q[LAST] ^ seen_q;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      en_sync_q <= '0;
      seen_q    <= 1'b0;
      dst_data  <= '0;
      dst_valid <= 1'b0;
    end else begin
      en_sync_q <= {en_sync_q[SYNC_STAGES-2:0], tog_q};
      seen_q    <= en_sync_q[LAST];
      dst_valid <= load;
      if (load) dst_data <= hold_q;
    end
  end
endmodule

module mcp_xfer_chk #(
  parameter int WIDTH = 16
) (
  input logic             src_clk,
  input logic             src_rst_n,
  input logic             src_valid,
  input logic             src_ready,
  input logic [WIDTH-1:0] hold_q,
  input logic             tog_q,
  input logic             dst_clk,
  input logic             dst_rst_n,
  input logic [WIDTH-1:0] dst_data,
  input logic             dst_valid
);
  assert_ready_drops_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_valid && src_ready) |=> !src_ready);
  assert_hold_stable_R3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_ready |=> $stable(hold_q));
  assert_busy_ignored_R8: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !(src_valid && src_ready) |=> $stable(tog_q));
  assert_single_pulse_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |=> !dst_valid);
  assert_data_only_on_valid_R5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !dst_valid |-> $stable(dst_data));
endmodule

bind mcp_xfer mcp_xfer_chk #(.WIDTH(WIDTH)) u_chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
  .src_ready(src_ready), .hold_q(hold_q), .tog_q(tog_q),
  .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_data(dst_data),
  .dst_valid(dst_valid)
);

// File: tb/test_mcp_xfer.sv
module test_mcp_xfer;
  localparam int W = 16;

  logic         src_clk = 0, dst_clk = 0;
  logic         src_rst_n = 0, dst_rst_n = 0;
  logic         src_valid = 0;
  logic [W-1:0] src_data = '0;
  logic         src_ready, dst_valid;
  logic [W-1:0] dst_data;

  int checks = 0, errors = 0, delivered = 0;
  int dst_half = 7;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_data = '0;
  logic         prev_valid = 0;
  bit           done = 0;

  mcp_xfer #(.WIDTH(W)) i_mcp_xfer (.*);

  always #10 src_clk = ~src_clk;
  initial forever #(dst_half) dst_clk = ~dst_clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_valid) begin
        chk(!prev_valid, "R4 pulse longer than one cycle", W'(prev_valid), '0);
        chk(exp_q.size() == 1, "R7 outstanding words at delivery", W'(exp_q.size()), W'(1));
        if (exp_q.size() > 0) begin
          chk(dst_data == exp_q[0], "R6 delivered word", dst_data, exp_q[0]);
          void'(exp_q.pop_front());
        end else chk(0, "R4 pulse with nothing accepted", dst_data, '0);
        delivered++;
      end else begin
        chk(dst_data == last_data, "R5 data changed without valid", dst_data, last_data);
      end
      last_data  = dst_data;
      prev_valid = dst_valid;
    end
  end

  task automatic send(input logic [W-1:0] v);
    int guard = 0;
    while (!src_ready && guard < 5000) begin
      src_valid = 1;
      src_data  = W'($urandom);
      @(negedge src_clk);
      guard++;
    end
    if (guard >= 5000) chk(0, "R4 ready never returned", '0, W'(1));
    src_valid = 1;
    src_data  = v;
    exp_q.push_back(v);
    @(negedge src_clk);
    chk(!src_ready, "R2 ready after accept", W'(src_ready), '0);
    src_valid = $urandom_range(0, 1);
    src_data  = W'($urandom);
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || !src_ready) && guard < 5000) begin
      src_valid = 0;
      @(negedge src_clk);
      guard++;
    end
    chk(exp_q.size() == 0, "R6 words left undelivered", W'(exp_q.size()), '0);
  endtask

  initial begin
    int sent = 0;
    repeat (3) @(negedge src_clk);
    chk(src_ready == 1, "R1 ready in reset", W'(src_ready), W'(1));
    chk(dst_valid == 0, "R1 valid in reset", W'(dst_valid), '0);
    chk(dst_data == '0, "R1 data in reset", dst_data, '0);
    src_rst_n = 1; dst_rst_n = 1;
    @(negedge src_clk);
    chk(src_ready == 1, "R1 ready after reset", W'(src_ready), W'(1));
    chk(dst_valid == 0, "R1 valid after reset", W'(dst_valid), '0);
    src_valid = 0;
    send(16'hFFFF); send(16'h0000); send(16'hA5A5); send(16'h5A5A);
    sent = 4;
    for (int i = 0; i < 40; i++) begin send(W'($urandom)); sent++; end
    drain();
    dst_half = 23;
    repeat (5) @(negedge src_clk);
    for (int i = 0; i < 40; i++) begin send(W'(16'h1000 + i)); sent++; end
    drain();
    dst_half = 10;
    for (int i = 0; i < 20; i++) begin send(W'($urandom)); sent++; end
    drain();
    chk(delivered == sent, "R4 delivery count", W'(delivered), W'(sent));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R4 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule